// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block sits on a management (MDIO) bus as a Clause 22 slave and gives a host access to a 32-bit switch register space that is much larger than one MDIO frame can name. The 5-bit PHY-address field of each frame is split. Its top two bits choose an access mode. Its low three bits are high register-address bits. A separately written page register supplies the upper address bits. Each 32-bit register is moved as two 16-bit MDIO transfers: a low half at the word address and a high half at that address plus two.

Writes stage the low half and issue one 32-bit write on the internal bus when the high half arrives. A low-half read fetches the whole word, returns the low half and keeps the high half. The next high-half read then returns a value consistent with that fetch. Frames whose mode selects pass-through belong to the embedded PHYs. For those frames the bridge only flags which PHY owns the bus. It never drives MDIO and never touches the internal bus.

MDC and MDIO are sampled in the system clock domain. MDC must stay high and low for at least five system clocks each.

Top module: `mdio_page_bridge`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones on MDIO, followed by start bits 0,1 and an opcode of 10 (read) or 01 (write). A frame with a short preamble or any other opcode causes no bus cycle.
- R2: PHY-address bits [4:3] pick the mode: 3 = page, 2 = register access, 0 = pass-through. Code 1 has no effect on the bus or the page.
- R3: A page-mode write stores data bits [9:0] as the page, which forms bus address bits [18:9]. A page-mode read leaves MDIO undriven (the line reads 0xFFFF) and issues no bus cycle.
- R4: In register mode the byte address is {page, PHY-address[2:0], register[4:0], 0}. Register bit 0 clear means the low half and set means the high half. The bus address is the word address {page, PHY-address[2:0], register[4:1], 00}.
- R5: A low-half write issues no bus cycle. A high-half write issues one bus write whose data is {high half, previously staged low half}.
- R6: A low-half read issues one bus read at the word address and returns bits [15:0] of the fetched word.
- R7: A high-half read issues no bus cycle. It returns bits [31:16] captured by the preceding low-half read, even if the register has since changed.
- R8: On a register-mode read the bridge leaves the first turnaround bit undriven, drives 0 in the second, then drives the 16 data bits MSB first and releases MDIO after the last bit.
- R9: In a pass-through frame, pass_act is high from the header to the frame end and pass_phy equals PHY-address[2:0]. MDIO is never driven and no bus cycle occurs.
- R10: Reset clears the page to 0, releases MDIO and holds both bus strobes low.
- R11: bus_wr and bus_rd are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | MDIO management clock from the host |
| mdio_i | input | 1 | MDIO line as seen at the pin |
| mdio_o | output | 1 | MDIO value driven by the bridge |
| mdio_oe | output | 1 | MDIO output enable |
| pass_act | output | 1 | A pass-through frame owns the bus |
| pass_phy | output | 3 | Embedded PHY selected by the pass-through frame |
| bus_addr | output | 19 | Internal bus byte address, word aligned |
| bus_wdata | output | 32 | Internal bus write data |
| bus_wr | output | 1 | Internal bus write strobe |
| bus_rd | output | 1 | Internal bus read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_rd |

## Verification
Each MDC rising edge reaches the frame engine three clocks later: two synchronizer stages and an edge register. The header and data strobes follow one clock after that. Bus strobes come one clock later again, and read data is captured two clocks after the header. The bench holds every MDC phase for six clocks and samples away from the clock edge, so a bit driven by the bridge settles before the host-side sample. Bus counters and captured addresses are checked only after a four-clock idle tail that follows each frame.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [1:0] {
    AM_BYPASS = 2'd0,
    AM_RSVD   = 2'd1,
    AM_REG    = 2'd2,
    AM_PAGE   = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    FS_PRE,
    FS_HDR,
    FS_TA,
    FS_DATA
  } frm_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  // start bit 2, opcode, 5-bit PHY address, 5-bit register
  localparam int HDR_BITS = 13;

  typedef struct packed {
    logic      rd;
    acc_mode_e mode;
    logic [2:0] sub;
    logic [4:0] reg_a;
  } frm_hdr_t;

endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES:0]   mdc_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dat_q <= '0;
    end else begin
      mdc_q <= {mdc_q[STAGES-1:0], mdc};
      dat_q <= {dat_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], mdio_i};
    end
  end

  assign bit_stb = mdc_q[STAGES-1] & ~mdc_q[STAGES];
  assign bit_val = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] tx_half,
  output logic              hdr_stb,
  output frm_hdr_t          hdr,
  output logic              dat_stb,
  output logic [DATA_W-1:0] dat,
  output logic              in_body,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int ONE_W   = $clog2(PRE_LEN + 1);
  localparam int CNT_MAX = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam logic [ONE_W-1:0] ONE_SAT = ONE_W'(PRE_LEN);

  frm_state_e        st_q, st_n;
  logic [ONE_W-1:0]  ones_q, ones_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  frm_hdr_t          hdr_q, hdr_n;
  logic              drv_q, drv_n;
  logic              oe_q, oe_n;
  logic              o_q, o_n;
  logic              hstb_q, hstb_n;
  logic              dstb_q, dstb_n;
  logic [HDR_BITS-1:0] hbits;
  logic [1:0]        h_op;
  logic              h_ok;

  always_comb begin
    hbits = {sh_q[HDR_BITS-2:0], bit_val};
    h_op  = hbits[11:10];
    h_ok  = hbits[HDR_BITS-1] && ((h_op == OP_RD) || (h_op == OP_WR));

    st_n   = st_q;
    ones_n = ones_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    tx_n   = tx_q;
    dat_n  = dat_q;
    hdr_n  = hdr_q;
    drv_n  = drv_q;
    oe_n   = oe_q;
    o_n    = o_q;
    hstb_n = 1'b0;
    dstb_n = 1'b0;

    if (bit_stb) begin
      unique case (st_q)
        FS_PRE: begin
          if (bit_val) begin
            if (ones_q != ONE_SAT) ones_n = ones_q + 1'b1;
          end else begin
            if (ones_q == ONE_SAT) begin
              st_n  = FS_HDR;
              cnt_n = '0;
            end
            ones_n = '0;
          end
        end
        FS_HDR: begin
          sh_n  = {sh_q[DATA_W-2:0], bit_val};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
            cnt_n = '0;
            if (h_ok) begin
              st_n        = FS_TA;
              hstb_n      = 1'b1;
              hdr_n.rd    = (h_op == OP_RD);
              hdr_n.mode  = acc_mode_e'(hbits[9:8]);
              hdr_n.sub   = hbits[7:5];
              hdr_n.reg_a = hbits[4:0];
              drv_n       = (h_op == OP_RD) && (acc_mode_e'(hbits[9:8]) == AM_REG);
            end else begin
              st_n = FS_PRE;
            end
          end
        end
        FS_TA: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == '0) begin
            // second turnaround bit: bridge drives zero on a register read
            oe_n = drv_q;
            o_n  = 1'b0;
          end else begin
            st_n  = FS_DATA;
            cnt_n = '0;
            o_n   = tx_half[DATA_W-1];
            tx_n  = {tx_half[DATA_W-2:0], 1'b0};
          end
        end
        FS_DATA: begin
          sh_n  = {sh_q[DATA_W-2:0], bit_val};
          cnt_n = cnt_q + 1'b1;
          o_n   = tx_q[DATA_W-1];
          tx_n  = {tx_q[DATA_W-2:0], 1'b0};
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            oe_n   = 1'b0;
            st_n   = FS_PRE;
            ones_n = '0;
            cnt_n  = '0;
            dat_n  = {sh_q[DATA_W-2:0], bit_val};
            dstb_n = !hdr_q.rd;
          end
        end
        default: st_n = FS_PRE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_PRE;
      ones_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      dat_q  <= '0;
      hdr_q  <= '0;
      drv_q  <= 1'b0;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      hstb_q <= 1'b0;
      dstb_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      ones_q <= ones_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      tx_q   <= tx_n;
      dat_q  <= dat_n;
      hdr_q  <= hdr_n;
      drv_q  <= drv_n;
      oe_q   <= oe_n;
      o_q    <= o_n;
      hstb_q <= hstb_n;
      dstb_q <= dstb_n;
    end
  end

  assign hdr_stb = hstb_q;
  assign hdr     = hdr_q;
  assign dat_stb = dstb_q;
  assign dat     = dat_q;
  assign in_body = (st_q == FS_TA) || (st_q == FS_DATA);
  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;

  // R8: the line is only driven in turnaround or data of a register read
  a_r8_oe_in_body: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> ((st_q == FS_TA) || (st_q == FS_DATA)));
  a_r8_oe_reg_read: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (hdr_q.rd && (hdr_q.mode == AM_REG)));
  // R1: header strobe marks one accepted frame
  a_r1_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hstb_q |=> !hstb_q);

endmodule

// File: rtl/mdio_reg_port.sv
module mdio_reg_port
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_stb,
  input  frm_hdr_t            hdr,
  input  logic                dat_stb,
  input  logic [DATA_W-1:0]   dat,
  input  logic [2*DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0]   tx_half,
  output logic [PAGE_W+8:0]   bus_addr,
  output logic [2*DATA_W-1:0] bus_wdata,
  output logic                bus_wr,
  output logic                bus_rd
);
  localparam int ADDR_W = PAGE_W + 9;
  localparam int WORD_W = 2 * DATA_W;

  logic [PAGE_W-1:0] page_q, page_n;
  logic [DATA_W-1:0] stage_q, stage_n;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [WORD_W-1:0] wd_q, wd_n;
  logic              wr_q, wr_n;
  logic              rd_q, rd_n;
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] word_a;

  always_comb begin
    word_a  = {page_q, hdr.sub, hdr.reg_a[4:1], 2'b00};
    page_n  = page_q;
    stage_n = stage_q;
    hold_n  = hold_q;
    tx_n    = tx_q;
    addr_n  = addr_q;
    wd_n    = wd_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    pend_n  = rd_q;

    if (pend_q) begin
      tx_n   = bus_rdata[DATA_W-1:0];
      hold_n = bus_rdata[WORD_W-1:DATA_W];
    end

    if (hdr_stb && hdr.rd && (hdr.mode == AM_REG)) begin
      if (!hdr.reg_a[0]) begin
        rd_n   = 1'b1;
        addr_n = word_a;
      end else begin
        tx_n = hold_q;
      end
    end

    if (dat_stb) begin
      unique case (hdr.mode)
        AM_PAGE: page_n = dat[PAGE_W-1:0];
        AM_REG: begin
          if (!hdr.reg_a[0]) begin
            stage_n = dat;
          end else begin
            wr_n   = 1'b1;
            addr_n = word_a;
            wd_n   = {dat, stage_q};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      stage_q <= '0;
      hold_q  <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      page_q  <= page_n;
      stage_q <= stage_n;
      hold_q  <= hold_n;
      tx_q    <= tx_n;
      addr_q  <= addr_n;
      wd_q    <= wd_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      pend_q  <= pend_n;
    end
  end

  assign tx_half   = tx_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wd_q;
  assign bus_wr    = wr_q;
  assign bus_rd    = rd_q;

  // R11: strobes are exclusive single-cycle pulses
  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q));
  a_r11_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);
  a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q);
  // R7: a high-half read is served without a bus cycle
  a_r7_hi_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_stb && hdr.rd && (hdr.mode == AM_REG) && hdr.reg_a[0]) |=> !rd_q);

endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mdc,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  pass_act,
  output logic [2:0]            pass_phy,
  output logic [PAGE_W+8:0]     bus_addr,
  output logic [2*DATA_W-1:0]   bus_wdata,
  output logic                  bus_wr,
  output logic                  bus_rd,
  input  logic [2*DATA_W-1:0]   bus_rdata
);
  logic [1:0]        rs_q;
  logic              rst_ni;
  logic              bit_stb, bit_val;
  logic              hdr_stb, dat_stb, in_body;
  frm_hdr_t          hdr;
  logic [DATA_W-1:0] dat, tx_half;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  mdio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_ni),
    .mdc     (mdc),
    .mdio_i  (mdio_i),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .tx_half (tx_half),
    .hdr_stb (hdr_stb),
    .hdr     (hdr),
    .dat_stb (dat_stb),
    .dat     (dat),
    .in_body (in_body),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  mdio_reg_port #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_ni),
    .hdr_stb   (hdr_stb),
    .hdr       (hdr),
    .dat_stb   (dat_stb),
    .dat       (dat),
    .bus_rdata (bus_rdata),
    .tx_half   (tx_half),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd)
  );

  assign pass_act = in_body && (hdr.mode == AM_BYPASS);
  assign pass_phy = hdr.sub;

  // R9: a pass-through frame leaves both MDIO and the bus alone
  a_r9_pass_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    pass_act |-> (!mdio_oe && !bus_wr && !bus_rd));
  // R10: nothing is driven while reset is held
  a_r10_reset_idle: assert property (@(posedge clk)
    !rst_ni |=> (!mdio_oe && !bus_wr && !bus_rd));

endmodule

// File: tb/tb_mdio_page_bridge.sv
module tb_mdio_page_bridge;
  localparam int HALF = 6;

  logic        clk, rst_n, mdc, m_drv, m_val;
  logic        mdio_o, mdio_oe, pass_act, bus_wr, bus_rd, line;
  logic [2:0]  pass_phy;
  logic [18:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [18:0] last_waddr, last_raddr;
  logic [31:0] last_wdata;
  logic        both_seen, pass_seen, oe_seen;
  logic [2:0]  pass_last;
  logic [15:0] salt;

  assign line = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);

  mdio_page_bridge dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .pass_act(pass_act), .pass_phy(pass_phy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // register model: low half fixed per address, high half follows salt
  always_ff @(posedge clk) begin
    if (bus_rd) begin
      bus_rdata  <= {bus_addr[15:0] ^ salt, bus_addr[15:0] ^ 16'h5A5A};
      rd_cnt     <= rd_cnt + 1;
      last_raddr <= bus_addr;
    end
    if (bus_wr) begin
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= bus_addr;
      last_wdata <= bus_wdata;
    end
    if (bus_wr && bus_rd) both_seen <= 1'b1;
    if (pass_act) begin
      pass_seen <= 1'b1;
      pass_last <= pass_phy;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] wa(input logic [9:0] pg, input logic [2:0] sb, input logic [4:0] ra);
    return {pg, sb, ra[4:1], 2'b00};
  endfunction

  task automatic mbit(input logic b, input logic rel, output logic s);
    @(negedge clk);
    mdc = 1'b0; m_drv = !rel; m_val = b;
    repeat (HALF) begin @(negedge clk); oe_seen |= mdio_oe; end
    s = line;
    mdc = 1'b1;
    repeat (HALF) begin @(negedge clk); oe_seen |= mdio_oe; end
  endtask

  task automatic xfer(input int pre, input logic [1:0] op, input logic [4:0] phy,
                      input logic [4:0] ra, input logic [15:0] wd,
                      output logic [15:0] rd, output logic ta1, output logic ta2);
    logic s;
    oe_seen = 1'b0; rd = '0; ta1 = 1'b1; ta2 = 1'b1;
    for (int i = 0; i < pre; i++) mbit(1'b1, 1'b0, s);
    mbit(1'b0, 1'b0, s); mbit(1'b1, 1'b0, s);
    for (int i = 1; i >= 0; i--) mbit(op[i], 1'b0, s);
    for (int i = 4; i >= 0; i--) mbit(phy[i], 1'b0, s);
    for (int i = 4; i >= 0; i--) mbit(ra[i], 1'b0, s);
    if (op == 2'b10) begin
      mbit(1'b1, 1'b1, ta1); mbit(1'b1, 1'b1, ta2);
      for (int i = 0; i < 16; i++) begin mbit(1'b1, 1'b1, s); rd = {rd[14:0], s}; end
    end else begin
      mbit(1'b1, 1'b0, s); mbit(1'b0, 1'b0, s);
      for (int i = 15; i >= 0; i--) mbit(wd[i], 1'b0, s);
    end
    @(negedge clk); m_drv = 1'b0; mdc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!mdio_oe, "R10 oe idle", 32'(mdio_oe), 0);
    chk(!bus_wr && !bus_rd, "R10 strobes idle", {bus_wr, bus_rd}, 0);
    chk(!pass_act, "R10 pass idle", 32'(pass_act), 0);
  endtask

  task automatic t_page_write;
    logic [15:0] r; logic a, b; int w0;
    w0 = wr_cnt;
    xfer(32, 2'b01, 5'b11000, 5'b00000, 16'hFEAB, r, a, b);   // page = 0x2AB
    chk(wr_cnt == w0, "R3 page write no bus", wr_cnt, w0);
    xfer(32, 2'b01, 5'b10101, 5'b01100, 16'h1234, r, a, b);
    chk(wr_cnt == w0, "R5 low half staged", wr_cnt, w0);
    xfer(32, 2'b01, 5'b10101, 5'b01101, 16'hBEEF, r, a, b);
    chk(wr_cnt == w0 + 1, "R5 R11 one write", wr_cnt, w0 + 1);
    chk(last_waddr == wa(10'h2AB, 3'd5, 5'b01100), "R4 R3 write addr", 32'(last_waddr), 32'(wa(10'h2AB, 3'd5, 5'b01100)));
    chk(last_wdata == 32'hBEEF1234, "R5 write data", last_wdata, 32'hBEEF1234);
  endtask

  task automatic t_read;
    logic [15:0] r; logic a, b; int r0; logic [18:0] ad;
    ad = wa(10'h2AB, 3'd6, 5'b00100);
    salt = 16'h0F0F; r0 = rd_cnt;
    xfer(32, 2'b10, 5'b10110, 5'b00100, 16'h0, r, a, b);
    chk(rd_cnt == r0 + 1, "R6 one fetch", rd_cnt, r0 + 1);
    chk(last_raddr == ad, "R6 R4 read addr", 32'(last_raddr), 32'(ad));
    chk(r == (ad[15:0] ^ 16'h5A5A), "R6 low data", r, ad[15:0] ^ 16'h5A5A);
    chk(a == 1'b1 && b == 1'b0, "R8 turnaround", {a, b}, 2'b10);
    salt = 16'hFFFF;
    xfer(32, 2'b10, 5'b10110, 5'b00101, 16'h0, r, a, b);
    chk(r == (ad[15:0] ^ 16'h0F0F), "R7 high coherent", r, ad[15:0] ^ 16'h0F0F);
    chk(rd_cnt == r0 + 1, "R7 no fetch", rd_cnt, r0 + 1);
    chk(!oe_seen || b == 1'b0, "R8 drive", 32'(oe_seen), 1);
  endtask

  task automatic t_page_read;
    logic [15:0] r; logic a, b; int r0;
    r0 = rd_cnt;
    xfer(32, 2'b10, 5'b11000, 5'b00000, 16'h0, r, a, b);
    chk(r == 16'hFFFF, "R3 page read undriven", r, 16'hFFFF);
    chk(!oe_seen && rd_cnt == r0, "R3 page read quiet", {oe_seen, 31'(rd_cnt - r0)}, 0);
  endtask

  task automatic t_bypass;
    logic [15:0] r; logic a, b; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt; pass_seen = 1'b0;
    xfer(32, 2'b01, 5'b00011, 5'b00001, 16'hAAAA, r, a, b);
    chk(pass_seen && pass_last == 3'd3, "R9 pass select", {pass_seen, pass_last}, {1'b1, 3'd3});
    xfer(32, 2'b10, 5'b00011, 5'b00010, 16'h0, r, a, b);
    chk(!oe_seen, "R9 no drive", 32'(oe_seen), 0);
    chk(rd_cnt == r0 && wr_cnt == w0, "R9 no bus", rd_cnt - r0 + wr_cnt - w0, 0);
    @(negedge clk);
    chk(!pass_act, "R9 pass ends", 32'(pass_act), 0);
    xfer(32, 2'b01, 5'b01101, 5'b01101, 16'h5555, r, a, b);
    chk(wr_cnt == w0, "R2 reserved mode", wr_cnt, w0);
  endtask

  task automatic t_reject;
    logic [15:0] r; logic a, b; int w0;
    w0 = wr_cnt;
    xfer(20, 2'b01, 5'b10101, 5'b01101, 16'h7777, r, a, b);
    chk(wr_cnt == w0, "R1 short preamble", wr_cnt, w0);
    xfer(32, 2'b11, 5'b10101, 5'b01101, 16'h7777, r, a, b);
    chk(wr_cnt == w0, "R1 bad opcode", wr_cnt, w0);
  endtask

  task automatic t_reset_page;
    logic [15:0] r; logic a, b;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mdio_oe && !bus_wr && !bus_rd, "R10 in reset", {mdio_oe, bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xfer(32, 2'b01, 5'b10001, 5'b00010, 16'h0102, r, a, b);
    xfer(32, 2'b01, 5'b10001, 5'b00011, 16'h0304, r, a, b);
    chk(last_waddr == wa(10'h0, 3'd1, 5'b00010), "R10 page cleared", 32'(last_waddr), 32'(wa(10'h0, 3'd1, 5'b00010)));
    chk(last_wdata == 32'h03040102, "R5 data after reset", last_wdata, 32'h03040102);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mdc = 1'b0; m_drv = 1'b0; m_val = 1'b1;
    salt = 16'h0; oe_seen = 1'b0; pass_seen = 1'b0; both_seen = 1'b0;
    pass_last = '0; bus_rdata = '0; last_waddr = '0; last_raddr = '0; last_wdata = '0;
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_page_write;
    t_read;
    t_page_read;
    t_bypass;
    t_reject;
    t_reset_page;
    chk(!both_seen, "R11 strobes exclusive", 32'(both_seen), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule